// File: doc/BRIEF.md
# Power-Up Restore and Store Gate Sequencer

This block sits beside the store/recall controller of a nonvolatile SRAM. It watches a digital supply-good flag that an external threshold comparator raises once the supply is above the switch level. When that flag rises, the sequencer asks the controller to recall the nonvolatile image into the SRAM. It then holds SRAM access off for a fixed number of clock cycles, and only after that interval does it open access.

The same supply indication gates store operations. A store may start only when the sequencer is ready and the supply is good. If the supply drops while the controller reports a store in flight, the sequencer emits a one-cycle abort. A write that is still being requested at the moment the restore finishes would corrupt data, so the sequencer flags that collision instead of letting it pass silently. If the supply drops during a restore, the sequencer returns to its off state. The next rise then starts a full new restore.

The supply flag passes through a synchroniser chain of `SYNC_STAGES` flops (2 by default). The restore length is `RESTORE_CYCLES` clock cycles (8 by default).

Top module: `pwrup_recall_seq`

## Requirements
- R1: While reset is asserted, and in the first cycles after release with supply-good low, `recall_req`, `access_en`, `store_allow`, `store_abort` and `wr_clash` are all 0.
- R2: A rise of `supply_ok_async` produces exactly one single-cycle `recall_req` pulse. The pulse goes high SYNC_STAGES+1 clock edges after the first edge that samples the rise. No further pulse follows while the supply stays good.
- R3: `access_en` goes high exactly RESTORE_CYCLES clock edges after `recall_req` goes high. It is low in every cycle before that.
- R4: `store_allow` is high only when the sequencer is ready and the synchronised supply is good. It drops SYNC_STAGES edges after `supply_ok_async` falls, one edge before `access_en` drops.
- R5: If the synchronised supply is seen low while ready and `store_busy` is high, `store_abort` pulses high for one cycle, SYNC_STAGES+1 edges after the fall. With `store_busy` low, no pulse occurs.
- R6: If `wr_req` is high on the edge where the restore completes, `wr_clash` pulses high for one cycle, coincident with `access_en` rising. With `wr_req` low, `wr_clash` stays 0.
- R7: A supply fall during a restore returns the sequencer to its off state and keeps `access_en` low. The next rise repeats the full restore, with a new `recall_req` pulse and the full RESTORE_CYCLES lockout.
- R8: `access_en` drops SYNC_STAGES+1 edges after `supply_ok_async` falls while ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok_async | input | 1 | Supply-above-threshold flag from the comparator, asynchronous |
| store_busy | input | 1 | Controller reports a store in flight |
| wr_req | input | 1 | An SRAM write is being requested |
| recall_req | output | 1 | Single-cycle request to start a recall |
| store_allow | output | 1 | A store may be started |
| store_abort | output | 1 | Single-cycle order to abandon the store in flight |
| access_en | output | 1 | SRAM reads and writes permitted |
| wr_clash | output | 1 | Single-cycle flag: a write was pending as the restore ended |

## Verification
Every result is registered, so its due cycle is a fixed count of edges after the input change. The synchroniser takes SYNC_STAGES edges, and the state register adds one. `recall_req`, `store_abort` and a drop of `access_en` are therefore due SYNC_STAGES+1 edges after a supply change, and `store_allow` falls one edge earlier. The rise of `access_en` and any `wr_clash` are due RESTORE_CYCLES edges after the recall pulse. When the driver changes an input, it queues each expected value tagged with the exact cycle at which it is due, including the cycle just before each transition. The monitor compares the outputs at the falling clock edge of that cycle.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;
   typedef enum logic [1:0] {
      PS_OFF     = 2'd0,
      PS_RESTORE = 2'd1,
      PS_READY   = 2'd2
   } pwr_state_t;
endpackage

// File: rtl/pwrup_seq_sync.sv
module pwrup_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwrup_seq_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pwrup_seq_timer.sv
module pwrup_seq_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt;

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("pwrup_seq_timer: CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LAST);

   AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(run)); // R3
endmodule

// File: rtl/pwrup_seq_flags.sv
module pwrup_seq_flags
   import pwrup_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_t state,
   input  logic       s_ok,
   input  logic       done,
   input  logic       store_busy,
   input  logic       wr_req,
   output logic       recall_req,
   output logic       store_abort,
   output logic       wr_clash
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recall_req  <= 1'b0;
         store_abort <= 1'b0;
         wr_clash    <= 1'b0;
      end else begin
         recall_req  <= (state == PS_OFF) && s_ok;
         store_abort <= (state == PS_READY) && !s_ok && store_busy;
         wr_clash    <= (state == PS_RESTORE) && s_ok && done && wr_req;
      end
   end

   AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      store_abort |-> ($past(store_busy) && !$past(s_ok) && $past(state) == PS_READY)); // R5
endmodule

// File: rtl/pwrup_recall_seq.sv
module pwrup_recall_seq
   import pwrup_seq_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int RESTORE_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok_async,
   input  logic store_busy,
   input  logic wr_req,
   output logic recall_req,
   output logic store_allow,
   output logic store_abort,
   output logic access_en,
   output logic wr_clash
);
   pwr_state_t state, state_nx;
   logic       s_ok;
   logic       done;
   logic       run;

   pwrup_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(supply_ok_async), .sync_out(s_ok)
   );

   assign run = (state == PS_RESTORE);

   pwrup_seq_timer #(.CYCLES(RESTORE_CYCLES)) timer_i (
      .clk(clk), .rst_n(rst_n), .run(run), .done(done)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         PS_OFF:     if (s_ok) state_nx = PS_RESTORE;
         PS_RESTORE: if (!s_ok) state_nx = PS_OFF;
                     else if (done) state_nx = PS_READY;
         PS_READY:   if (!s_ok) state_nx = PS_OFF;
         default:    state_nx = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_OFF;
      else        state <= state_nx;
   end

   pwrup_seq_flags flags_i (
      .clk(clk), .rst_n(rst_n), .state(state), .s_ok(s_ok), .done(done),
      .store_busy(store_busy), .wr_req(wr_req),
      .recall_req(recall_req), .store_abort(store_abort), .wr_clash(wr_clash)
   );

   assign access_en   = (state == PS_READY);
   assign store_allow = (state == PS_READY) && s_ok;

   AST_RECALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |-> (state == PS_RESTORE && $past(state) == PS_OFF)); // R2
   AST_READY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_READY && $past(state) != PS_READY) |-> ($past(state) == PS_RESTORE && $past(done))); // R3
   AST_ALLOW_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      store_allow |-> (s_ok && $past(s_ok))); // R4
   AST_CLASH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clash |-> ($past(wr_req) && state == PS_READY)); // R6
   AST_FALL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) != PS_OFF && !$past(s_ok)) |-> state == PS_OFF); // R7
endmodule

// File: tb/pwrup_recall_seq_tb.sv
module pwrup_recall_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC = 2;
   localparam int RCYC = 8;
   localparam logic [4:0] M_RC = 5'b10000;
   localparam logic [4:0] M_AE = 5'b01000;
   localparam logic [4:0] M_SA = 5'b00100;
   localparam logic [4:0] M_AB = 5'b00010;
   localparam logic [4:0] M_WC = 5'b00001;

   typedef struct {
      int         cyc;
      logic [4:0] mask;
      logic [4:0] val;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok_async = 1'b0;
   logic store_busy = 1'b0;
   logic wr_req = 1'b0;
   logic recall_req, store_allow, store_abort, access_en, wr_clash;
   logic [4:0] obs;
   int cyc = 0;
   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   exp_t sb[$];

   pwrup_recall_seq #(.SYNC_STAGES(SYNC), .RESTORE_CYCLES(RCYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .supply_ok_async(supply_ok_async),
      .store_busy(store_busy), .wr_req(wr_req),
      .recall_req(recall_req), .store_allow(store_allow),
      .store_abort(store_abort), .access_en(access_en), .wr_clash(wr_clash)
   );

   assign obs = {recall_req, access_en, store_allow, store_abort, wr_clash};

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic compare(logic [4:0] m, logic [4:0] v, string tag);
      checks++;
      if ((obs & m) !== (v & m)) begin
         failures++;
         $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b", tag, cyc, obs & m, v & m, m);
      end
   endtask

   task automatic expect_at(int d, logic [4:0] m, logic [4:0] v, string tag);
      sb.push_back('{cyc + d, m, v, tag});
   endtask

   // monitor: compares due entries at the falling edge
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].cyc == cyc) begin
            compare(sb[i].mask, sb[i].val, sb[i].tag);
            sb.delete(i);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(5'b11111, 5'b00000, "R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      compare(5'b11111, 5'b00000, "R1 after reset");

      // plain power-up, no write pending
      supply_ok_async = 1'b1;
      expect_at(SYNC,          M_RC | M_AE | M_SA, 5'b00000, "R2 no early recall");
      expect_at(SYNC + 1,      M_RC | M_AE,        M_RC,     "R2 recall pulse");
      expect_at(SYNC + 2,      M_RC,               5'b00000, "R2 single pulse");
      expect_at(SYNC + RCYC,   M_AE | M_SA,        5'b00000, "R3 still locked");
      expect_at(SYNC + 1 + RCYC, M_AE | M_SA | M_WC, M_AE | M_SA, "R3 access opens, R6 no clash");
      expect_at(SYNC + 6 + RCYC, M_RC | M_WC,      5'b00000, "R2 no retrigger");
      repeat (SYNC + RCYC + 8) @(negedge clk);

      // supply fall while a store is in flight
      store_busy = 1'b1;
      supply_ok_async = 1'b0;
      expect_at(SYNC - 1, M_SA | M_AE, M_SA | M_AE, "R4 allow before sync");
      expect_at(SYNC,     M_SA | M_AE | M_AB, M_AE, "R4 allow drops");
      expect_at(SYNC + 1, M_AB | M_AE | M_SA, M_AB, "R5 abort pulse, R8 access drops");
      expect_at(SYNC + 2, M_AB,               5'b00000, "R5 abort single");
      repeat (SYNC + 5) @(negedge clk);
      store_busy = 1'b0;

      // power-up with a write still requested at the end of restore
      wr_req = 1'b1;
      supply_ok_async = 1'b1;
      expect_at(SYNC + 1,        M_RC, M_RC, "R2 recall second rise");
      expect_at(SYNC + RCYC,     M_WC | M_AE, 5'b00000, "R6 no early clash");
      expect_at(SYNC + 1 + RCYC, M_WC | M_AE, M_WC | M_AE, "R6 clash flagged");
      expect_at(SYNC + 2 + RCYC, M_WC, 5'b00000, "R6 clash single");
      repeat (SYNC + RCYC + 5) @(negedge clk);
      wr_req = 1'b0;

      // fall with no store in flight
      supply_ok_async = 1'b0;
      expect_at(SYNC + 1, M_AB | M_AE, 5'b00000, "R5 no abort when idle, R8");
      expect_at(SYNC + 2, M_AB | M_SA, 5'b00000, "R5 still no abort");
      repeat (SYNC + 5) @(negedge clk);

      // fall during restore, then full restart
      supply_ok_async = 1'b1;
      expect_at(SYNC + 1, M_RC, M_RC, "R7 first recall");
      repeat (5) @(negedge clk);
      supply_ok_async = 1'b0;
      expect_at(SYNC + 1, M_AE | M_RC, 5'b00000, "R7 aborted restore");
      expect_at(SYNC + 4, M_AE | M_SA, 5'b00000, "R7 stays locked");
      repeat (SYNC + 5) @(negedge clk);
      supply_ok_async = 1'b1;
      expect_at(SYNC + 1,        M_RC | M_AE, M_RC, "R7 restart recall");
      expect_at(SYNC + RCYC,     M_AE, 5'b00000, "R7 full lockout again");
      expect_at(SYNC + 1 + RCYC, M_AE | M_SA | M_WC, M_AE | M_SA, "R7 ready after full restore");
      repeat (SYNC + RCYC + 4) @(negedge clk);

      foreach (sb[i]) begin
         failures++;
         $display("FAIL %s never checked (due cyc=%0d) actual=none expected=%b", sb[i].tag, sb[i].cyc, sb[i].val);
      end
      finish_run();
   end
endmodule